// File: doc/BRIEF.md
# Front-Panel LED and CPU Clock Controller

This block runs the debug front panel of a board that hosts a small 8-bit CPU. It drives three rows of eight LEDs and one clock indicator lamp:

- The status row shows the arithmetic flags, the CPU reset state and the current speed step.
- The data row shows the value of the register picked by the panel. While the CPU is held in reset, it shows the DIP switches instead.
- The program-counter row shows the PC. The indicator lamp beside that row toggles at the CPU's effective clock rate.

The CPU does not get a separate clock. It runs from the system clock and is gated by a clock-enable pulse. That pulse comes once every 2^k system cycles, and k is picked by an eight-step speed setting. The left and right buttons lower and raise the speed. Holding either button makes the adjustment repeat automatically. The up and down buttons move the register-select index that goes out to the CPU's register read port. The centre button holds the CPU in reset. Every button passes through a two-flop synchroniser before it is used. All buttons except the centre button also pass through a rising-edge detector.

Top module: `fp_panel`

## Requirements
- R1: While rst_ni is low, cpu_rst_o is 1, reg_sel_o is 0, all three LED rows are 0 and led_tick_o is 0. The speed step takes the value STEP_RST.
- R2: The status row is registered one cycle after its inputs. Bit 7 is carry (flags_i[3]), bit 6 is zero (flags_i[2]), bit 5 is sign (flags_i[1]) and bit 4 is overflow (flags_i[0]). Bit 3 is cpu_rst_o and bits 2:0 are the speed step, 0 = slowest and 7 = fastest.
- R3: While cpu_rst_o is 0, the data row shows reg_data_i, one cycle late.
- R4: While cpu_rst_o is 1, the data row shows dip_i, one cycle late, and ignores reg_data_i.
- R5: The PC row shows pc_i, one cycle late.
- R6: led_tick_o inverts once for each cycle in which cpu_ce_o is 1, and holds otherwise.
- R7: cpu_ce_o pulses once every 2^(MIN_SHIFT + 7 − step) system cycles.
- R8: A press of the right button raises the step by one and a press of the left button lowers it by one. The step saturates at 7 and at 0.
- R9: Holding left or right repeats the adjustment. The first repeat comes HOLD_CYC cycles after the first step, and later repeats come every RPT_CYC cycles. A hold shorter than HOLD_CYC gives exactly one step.
- R10: A press of the up button raises reg_sel_o by one and a press of the down button lowers it by one, both modulo 8. Holding up or down gives only one step.
- R11: cpu_rst_o follows btn_ctr_i through a two-flop synchroniser, so it changes two cycles after the button does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_left_i | input | 1 | Lower CPU speed |
| btn_right_i | input | 1 | Raise CPU speed |
| btn_up_i | input | 1 | Next register |
| btn_down_i | input | 1 | Previous register |
| btn_ctr_i | input | 1 | Hold CPU in reset |
| dip_i | input | 8 | DIP switch bus |
| flags_i | input | 4 | {carry, zero, sign, overflow} |
| pc_i | input | 8 | CPU program counter |
| reg_data_i | input | 8 | Value of the selected register |
| led_stat_o | output | 8 | Status LED row |
| led_data_o | output | 8 | Data LED row |
| led_pc_o | output | 8 | Program-counter LED row |
| led_tick_o | output | 1 | CPU clock indicator lamp beside the PC row |
| reg_sel_o | output | 3 | Register select index |
| cpu_ce_o | output | 1 | CPU clock enable |
| cpu_rst_o | output | 1 | CPU reset, active high |

## Verification
The bench builds the block with HOLD_CYC = 20, RPT_CYC = 5, MIN_SHIFT = 0 and STEP_RST = 3. The short hold and repeat delays let one test drive a press that stops just short of the first repeat and a hold that runs through several repeats into saturation. With MIN_SHIFT = 0, the slowest divider period is 128 cycles and the fastest gives an enable every cycle. Clock-enable rates are checked by counting pulses over windows that are whole multiples of the expected period.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int LED_W     = 8;
  localparam int NUM_STEPS = 8;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int NUM_REGS  = 8;
  localparam int SEL_W     = $clog2(NUM_REGS);
  localparam int NUM_DIR   = 4;

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [SEL_W-1:0]  sel_t;

  localparam step_t STEP_MAX = step_t'(NUM_STEPS - 1);

  // Index of each directional button in the conditioned-button vector.
  localparam int DIR_LEFT  = 0;
  localparam int DIR_RIGHT = 1;
  localparam int DIR_UP    = 2;
  localparam int DIR_DOWN  = 3;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic ovf;
  } cpu_flags_t;
endpackage

// File: rtl/fp_sync.sv
module fp_sync #(
  parameter int       W       = 1,
  parameter bit       RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_VAL}};
      stab_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/fp_btn.sv
module fp_btn #(
  parameter bit          REPEAT   = 1'b0,
  parameter int unsigned HOLD_CYC = 20,
  parameter int unsigned RPT_CYC  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic fire_o
);
  localparam int unsigned LIM  = (HOLD_CYC > RPT_CYC) ? HOLD_CYC : RPT_CYC;
  localparam int          CNTW = $clog2(LIM + 1);

  logic lvl;
  logic prev_q;
  logic rise;

  fp_sync #(.W(1), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  generate
    if (REPEAT) begin : g_rpt
      localparam logic [CNTW-1:0] HOLD_LAST = CNTW'(HOLD_CYC - 1);
      localparam logic [CNTW-1:0] RPT_LAST  = CNTW'(RPT_CYC - 1);
      logic [CNTW-1:0] cnt_q, cnt_d;
      logic            armed_q, armed_d;
      logic            hit;

      always_comb begin
        hit     = 1'b0;
        cnt_d   = cnt_q;
        armed_d = armed_q;
        if (!lvl || rise) begin
          cnt_d   = '0;
          armed_d = 1'b0;
        end else if ((!armed_q && cnt_q == HOLD_LAST) ||
                     ( armed_q && cnt_q == RPT_LAST)) begin
          hit     = 1'b1;
          cnt_d   = '0;
          armed_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
        end else begin
          cnt_q   <= cnt_d;
          armed_q <= armed_d;
        end
      end

      assign fire_o = rise | hit;
    end else begin : g_edge
      assign fire_o = rise;
    end
  endgenerate
endmodule

// File: rtl/fp_clkdiv.sv
module fp_clkdiv
  import fp_pkg::*;
#(
  parameter int unsigned MIN_SHIFT = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  step_t step_i,
  output logic  ce_o
);
  localparam int CW  = MIN_SHIFT + NUM_STEPS - 1;
  localparam int SHW = $clog2(CW + 1);

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW:0]    span;
  logic [SHW-1:0] shamt;
  logic           ce_d, ce_q;

  always_comb begin
    shamt = SHW'(MIN_SHIFT) + SHW'(STEP_MAX - step_i);
    span  = ({{CW{1'b0}}, 1'b1} << shamt) - 1'b1;
    ce_d  = ((cnt_q & span[CW-1:0]) == '0);
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ce_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ce_q  <= ce_d;
    end
  end

  assign ce_o = ce_q;
endmodule

// File: rtl/fp_panel.sv
module fp_panel
  import fp_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 25_000_000,
  parameter int unsigned RPT_CYC   = 5_000_000,
  parameter int unsigned MIN_SHIFT = 16,
  parameter int unsigned STEP_RST  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             btn_left_i,
  input  logic             btn_right_i,
  input  logic             btn_up_i,
  input  logic             btn_down_i,
  input  logic             btn_ctr_i,
  input  logic [LED_W-1:0] dip_i,
  input  logic [3:0]       flags_i,
  input  logic [LED_W-1:0] pc_i,
  input  logic [LED_W-1:0] reg_data_i,
  output logic [LED_W-1:0] led_stat_o,
  output logic [LED_W-1:0] led_data_o,
  output logic [LED_W-1:0] led_pc_o,
  output logic             led_tick_o,
  output logic [SEL_W-1:0] reg_sel_o,
  output logic             cpu_ce_o,
  output logic             cpu_rst_o
);
  localparam step_t STEP_INIT = step_t'(STEP_RST);

  logic [NUM_DIR-1:0] raw_dir;
  logic [NUM_DIR-1:0] fire;
  logic               hold_rst;
  cpu_flags_t         flg;

  step_t step_q, step_d;
  sel_t  sel_q, sel_d;
  logic  tick_q, tick_d;
  logic [LED_W-1:0] stat_q, stat_d, data_q, data_d, pc_q;

  assign raw_dir[DIR_LEFT]  = btn_left_i;
  assign raw_dir[DIR_RIGHT] = btn_right_i;
  assign raw_dir[DIR_UP]    = btn_up_i;
  assign raw_dir[DIR_DOWN]  = btn_down_i;

  // Speed buttons auto-repeat; register-select buttons act on the edge only.
  for (genvar i = 0; i < NUM_DIR; i++) begin : g_btn
    fp_btn #(
      .REPEAT  (i == DIR_LEFT || i == DIR_RIGHT),
      .HOLD_CYC(HOLD_CYC),
      .RPT_CYC (RPT_CYC)
    ) u_btn (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_dir[i]),
      .fire_o(fire[i])
    );
  end

  fp_sync #(.W(1), .RST_VAL(1'b1)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_ctr_i),
    .q_o   (hold_rst)
  );

  fp_clkdiv #(.MIN_SHIFT(MIN_SHIFT)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step_q),
    .ce_o  (cpu_ce_o)
  );

  always_comb begin
    flg    = cpu_flags_t'(flags_i);
    step_d = step_q;
    if (fire[DIR_RIGHT]) begin
      if (step_q != STEP_MAX) step_d = step_q + 1'b1;
    end else if (fire[DIR_LEFT]) begin
      if (step_q != '0) step_d = step_q - 1'b1;
    end
    sel_d = sel_q;
    if (fire[DIR_UP])        sel_d = sel_q + 1'b1;
    else if (fire[DIR_DOWN]) sel_d = sel_q - 1'b1;
    tick_d = tick_q ^ cpu_ce_o;
    stat_d = {flg.carry, flg.zero, flg.sign, flg.ovf, hold_rst, step_q};
    data_d = hold_rst ? dip_i : reg_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= STEP_INIT;
      sel_q  <= '0;
      tick_q <= 1'b0;
      stat_q <= '0;
      data_q <= '0;
      pc_q   <= '0;
    end else begin
      step_q <= step_d;
      sel_q  <= sel_d;
      tick_q <= tick_d;
      stat_q <= stat_d;
      data_q <= data_d;
      pc_q   <= pc_i;
    end
  end

  assign led_stat_o = stat_q;
  assign led_data_o = data_q;
  assign led_pc_o   = pc_q;
  assign led_tick_o = tick_q;
  assign reg_sel_o  = sel_q;
  assign cpu_rst_o  = hold_rst;
endmodule

// File: rtl/fp_panel_chk.sv
module fp_panel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       btn_ctr_i,
  input logic [7:0] dip_i,
  input logic [7:0] pc_i,
  input logic [7:0] reg_data_i,
  input logic [7:0] led_data_o,
  input logic [7:0] led_pc_o,
  input logic       led_tick_o,
  input logic       cpu_ce_o,
  input logic       cpu_rst_o,
  input logic [2:0] reg_sel_o,
  input logic [2:0] step_q
);
  p_data_dip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cpu_rst_o)) |-> led_data_o == $past(dip_i));

  p_data_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(cpu_rst_o)) |-> led_data_o == $past(reg_data_i));

  p_pc_row_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> led_pc_o == $past(pc_i));

  p_tick_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cpu_ce_o)) |-> led_tick_o != $past(led_tick_o));

  p_tick_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(cpu_ce_o)) |-> $stable(led_tick_o));

  p_step_unit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$stable(step_q)) |->
      (step_q == $past(step_q) + 3'd1 || step_q == $past(step_q) - 3'd1));

  p_sel_unit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$stable(reg_sel_o)) |->
      (reg_sel_o == $past(reg_sel_o) + 3'd1 || reg_sel_o == $past(reg_sel_o) - 3'd1));

  p_rst_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 1) && $past(rst_ni, 2)) |-> cpu_rst_o == $past(btn_ctr_i, 2));
endmodule

bind fp_panel fp_panel_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .btn_ctr_i (btn_ctr_i),
  .dip_i     (dip_i),
  .pc_i      (pc_i),
  .reg_data_i(reg_data_i),
  .led_data_o(led_data_o),
  .led_pc_o  (led_pc_o),
  .led_tick_o(led_tick_o),
  .cpu_ce_o  (cpu_ce_o),
  .cpu_rst_o (cpu_rst_o),
  .reg_sel_o (reg_sel_o),
  .step_q    (step_q)
);

// File: tb/tb_fp_panel.sv
module tb_fp_panel;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       b_l, b_r, b_u, b_d, b_c;
  logic [7:0] dip, pc, rdat;
  logic [3:0] flags;
  logic [7:0] led_stat, led_data, led_pc;
  logic       led_tick, cpu_ce, cpu_rst;
  logic [2:0] reg_sel;

  always #10 clk = ~clk;

  fp_panel #(.HOLD_CYC(20), .RPT_CYC(5), .MIN_SHIFT(0), .STEP_RST(3)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .btn_left_i(b_l), .btn_right_i(b_r), .btn_up_i(b_u), .btn_down_i(b_d), .btn_ctr_i(b_c),
    .dip_i(dip), .flags_i(flags), .pc_i(pc), .reg_data_i(rdat),
    .led_stat_o(led_stat), .led_data_o(led_data), .led_pc_o(led_pc), .led_tick_o(led_tick),
    .reg_sel_o(reg_sel), .cpu_ce_o(cpu_ce), .cpu_rst_o(cpu_rst)
  );

  // fld: 0 status row, 1 data row, 2 pc row, 3 reg select, 4 cpu reset, 5 speed step, 6 measured value
  typedef struct {
    string tag;
    int    fld;
    int    exp;
    int    act;
  } item_t;

  item_t sb[$];
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  function automatic int pick(int fld, int given);
    case (fld)
      0: return int'(led_stat);
      1: return int'(led_data);
      2: return int'(led_pc);
      3: return int'(reg_sel);
      4: return int'(cpu_rst);
      5: return int'(led_stat[2:0]);
      default: return given;
    endcase
  endfunction

  // Monitor: compares queued expectations against the outputs, away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        int    a;
        it = sb.pop_front();
        a  = pick(it.fld, it.act);
        nchk++;
        if (a != it.exp) begin
          nerr++;
          $display("FAIL %s: actual %0d expected %0d", it.tag, a, it.exp);
        end
      end
    end
  end

  task automatic expect_out(string tag, int fld, int exp);
    item_t it;
    @(posedge clk); #1;
    it.tag = tag; it.fld = fld; it.exp = exp; it.act = 0;
    sb.push_back(it);
  endtask

  task automatic expect_val(string tag, int exp, int act);
    item_t it;
    it.tag = tag; it.fld = 6; it.exp = exp; it.act = act;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hold_btn(int which, int n);
    @(negedge clk);
    case (which) 0: b_l = 1; 1: b_r = 1; 2: b_u = 1; default: b_d = 1; endcase
    idle(n);
    case (which) 0: b_l = 0; 1: b_r = 0; 2: b_u = 0; default: b_d = 0; endcase
    idle(6);
  endtask

  task automatic count_ce(string tag, int win, int exp);
    int ces = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (cpu_ce) ces++;
    end
    expect_val(tag, exp, ces);
  endtask

  task automatic count_tick(string tag, int win, int exp);
    int flips = 0;
    logic last;
    @(negedge clk);
    last = led_tick;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (led_tick != last) flips++;
      last = led_tick;
    end
    expect_val(tag, exp, flips);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; b_l = 0; b_r = 0; b_u = 0; b_d = 0; b_c = 0;
    dip = 8'hA5; rdat = 8'h3C; pc = 8'h12; flags = 4'b1010;
    idle(3);
    expect_out("R1 cpu reset during reset", 4, 1);
    expect_out("R1 select during reset", 3, 0);
    expect_out("R1 status row during reset", 0, 0);
    expect_out("R1 data row during reset", 1, 0);
    @(negedge clk); rst_ni = 1;
    idle(4);
    expect_out("R1 step after reset", 5, 3);
    expect_out("R2 status row", 0, 8'hA3);
    expect_out("R3 data row shows register", 1, 8'h3C);
    expect_out("R5 pc row", 2, 8'h12);
    @(negedge clk); flags = 4'b0101; rdat = 8'h77; pc = 8'h80;
    idle(2);
    expect_out("R2 status row flags moved", 0, 8'h53);
    expect_out("R3 data row follows register", 1, 8'h77);
    expect_out("R5 pc row follows pc", 2, 8'h80);
    @(negedge clk); b_c = 1;
    idle(4);
    expect_out("R11 cpu reset from centre button", 4, 1);
    expect_out("R4 data row shows switches", 1, 8'hA5);
    expect_out("R2 status shows cpu reset", 0, 8'h5B);
    @(negedge clk); dip = 8'h0F; rdat = 8'h99;
    idle(2);
    expect_out("R4 switches, register ignored", 1, 8'h0F);
    @(negedge clk); b_c = 0; rdat = 8'h77;
    idle(4);
    expect_out("R11 cpu reset released", 4, 0);
    expect_out("R3 data row back to register", 1, 8'h77);
    count_ce("R7 enable rate at step 3", 64, 4);
    count_tick("R6 indicator flips at step 3", 64, 4);
    hold_btn(1, 3);
    expect_out("R8 right raises step", 5, 4);
    hold_btn(0, 3); hold_btn(0, 3);
    expect_out("R8 left lowers step", 5, 2);
    for (int k = 0; k < 5; k++) hold_btn(0, 3);
    expect_out("R8 step saturates at 0", 5, 0);
    count_ce("R7 enable rate at step 0", 256, 2);
    hold_btn(1, 38);
    expect_out("R9 hold repeats", 5, 5);
    hold_btn(1, 19);
    expect_out("R9 hold below delay gives one step", 5, 6);
    hold_btn(1, 38);
    expect_out("R8 step saturates at 7", 5, 7);
    count_ce("R7 enable rate at step 7", 16, 16);
    hold_btn(2, 3);
    expect_out("R10 up raises select", 3, 1);
    hold_btn(3, 3); hold_btn(3, 3);
    expect_out("R10 down wraps below 0", 3, 7);
    hold_btn(2, 3);
    expect_out("R10 up wraps above 7", 3, 0);
    hold_btn(2, 38);
    expect_out("R10 held up steps once", 3, 1);
    idle(2);
    wait (sb.size() == 0);
    idle(1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule